// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller sits between a fast SRAM array and the nonvolatile shadow array behind it. It decides when SRAM contents are saved into the shadow array (a store) and when shadow contents are brought back into the SRAM (a recall). It grants or withholds the SRAM read and write requests of the host. It controls a shared, active-low busy line that works in two directions. An external agent pulls the line low to request a store, and the controller holds it low to report that an operation is running.

There are three ways to start a store: the busy line, a software command pulse, or a supply-fail indication. Stores from the busy line and from supply fail are skipped when no SRAM write has happened since the last store or recall. A software store always runs. There are two ways to start a recall: a software command, and the return of supply. A pending access is given a grace window before each operation begins. Every array step is timed by a cycle-count parameter and is also acknowledged by the array. The array is a behavioural model in the testbench, driven by level strobes, one per step.

An autostore-enable bit chooses whether a supply fail triggers a store. Software can change this bit at any time. The change is kept across a power loss only after a later store started from the pin or by software.

Top module: `nv_shadow_seq`

## Requirements
- R1: After reset the busy line is not driven low or high, `auto_enable` is 1 and `write_latched` is 0. With supply good and the line high, a read request is granted in the same cycle.
- R2: A granted write sets `write_latched` on the next clock. The flag is cleared when a store's program step completes or when a recall's copy step completes.
- R3: Suppose the busy line goes low while `write_latched` is 0. The controller does not drive the line, starts no array step, and grants no read or write until the line is high again.
- R4: Suppose the busy line goes low while `write_latched` is 1. The controller holds the line low for GRACE_CYC grace cycles, then ERASE_CYC erase cycles, then PROG_CYC program cycles. During the grace cycles reads are granted and writes are not.
- R5: After a store started from the pin or by software, `busy_drive_high` is asserted for HIGH_CYC cycles and is never asserted together with `busy_drive_low`. After that the controller stays idle-blocked until the line reads high.
- R6: `sw_store_go` starts the same grace/erase/program sequence whatever the value of `write_latched`.
- R7: `sw_recall_go` causes GRACE_CYC grace cycles, then CLEAR_CYC cycles of `sram_clear`, then COPY_CYC cycles of `nv_to_sram`, with the busy line held low throughout. The SRAM ends up holding the shadow data, and the shadow data is unchanged.
- R8: When `pwr_ok` falls, a store (grace, erase, program, no high pulse) runs only if `auto_enable` and `write_latched` are both 1. No read or write is granted while `pwr_ok` is 0.
- R9: When `pwr_ok` rises again, a recall runs with CLEAR_CYC clear cycles and PUP_COPY_CYC copy cycles, and the line is held low throughout. `auto_enable` is reloaded from its saved copy.
- R10: A `sw_auto_cfg_go` pulse in idle sets `auto_enable` to `sw_auto_cfg_val` on the next clock. The saved copy takes the live value only when a store started from the pin or by software completes.
- R11: At most one array step strobe is active at a time. While one is active, no read or write is granted and the busy line is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Supply above switch threshold |
| acc_rd_req | input | 1 | Host SRAM read request |
| acc_wr_req | input | 1 | Host SRAM write request |
| acc_rd_grant | output | 1 | Read passed to the SRAM |
| acc_wr_grant | output | 1 | Write passed to the SRAM |
| sw_store_go | input | 1 | Software store command pulse |
| sw_recall_go | input | 1 | Software recall command pulse |
| sw_auto_cfg_go | input | 1 | Software autostore-enable update pulse |
| sw_auto_cfg_val | input | 1 | New autostore-enable value |
| busy_pin_in | input | 1 | Resolved level of the shared busy line |
| busy_drive_low | output | 1 | Pull the busy line low |
| busy_drive_high | output | 1 | Actively drive the busy line high |
| nv_erase | output | 1 | Erase step strobe to the shadow array |
| nv_program | output | 1 | Program step strobe (SRAM to shadow) |
| sram_clear | output | 1 | SRAM clear step strobe |
| nv_to_sram | output | 1 | Copy step strobe (shadow to SRAM) |
| array_done | input | 1 | Array acknowledges the current step |
| write_latched | output | 1 | A write happened since the last store or recall |
| auto_enable | output | 1 | Live autostore-enable bit |

## Verification
The assertions check the following on every cycle: the single-strobe rule, the ban on grants during array steps and while supply is low, the erase-then-program and clear-then-copy ordering, the set and clear of the write flag, and the rule that the line is never driven both ways at once. The bench scenarios are needed for everything that depends on counting or on data. That covers the exact length of each window, the skip decision for each trigger source crossed with the write-flag state, the high pulse and hold after a store, the survival of the autostore setting across a power loss, and the data a recall brings back into the SRAM.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GRACE, ST_ERASE, ST_PROG, ST_HIGH,
    ST_HOLD, ST_CLEAR, ST_COPY, ST_OFF
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_PIN, OP_SOFT, OP_AUTO, OP_SOFT_RECALL, OP_POWERUP
  } op_kind_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // software stores ignore the write flag; pin and supply-fail stores need it
  function automatic logic store_qualifies(op_kind_e k, logic latched);
    return (k == OP_SOFT) || latched;
  endfunction

  // only manually started stores make the autostore setting persistent
  function automatic logic saves_config(op_kind_e k);
    return (k == OP_PIN) || (k == OP_SOFT);
  endfunction

  function automatic logic drives_busy(seq_state_e s);
    return s inside {ST_GRACE, ST_ERASE, ST_PROG, ST_CLEAR, ST_COPY};
  endfunction

  function automatic logic is_array_step(seq_state_e s);
    return s inside {ST_ERASE, ST_PROG, ST_CLEAR, ST_COPY};
  endfunction

endpackage

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/nvs_access_gate.sv
module nvs_access_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic rd_open,
  input  logic wr_open,
  input  logic rd_req,
  input  logic wr_req,
  input  logic latch_clear,
  output logic rd_grant,
  output logic wr_grant,
  output logic latched
);
  assign rd_grant = rd_req && rd_open && pwr_ok;
  assign wr_grant = wr_req && wr_open && pwr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)           latched <= 1'b0;
    else if (latch_clear) latched <= 1'b0;
    else if (wr_grant)    latched <= 1'b1;
  end
endmodule

// File: rtl/nvs_auto_cfg.sv
module nvs_auto_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_go,
  input  logic cfg_val,
  input  logic save,
  input  logic reload,
  output logic auto_enable
);
  logic live_q, saved_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q  <= 1'b1;
      saved_q <= 1'b1;
    end else begin
      if (save)        saved_q <= live_q;
      if (reload)      live_q  <= saved_q;
      else if (cfg_go) live_q  <= cfg_val;
    end
  end

  assign auto_enable = live_q;
endmodule

// File: rtl/nv_shadow_seq.sv
module nv_shadow_seq
  import nvs_pkg::*;
#(
  parameter int GRACE_CYC    = 3,
  parameter int ERASE_CYC    = 4,
  parameter int PROG_CYC     = 5,
  parameter int HIGH_CYC     = 2,
  parameter int CLEAR_CYC    = 2,
  parameter int COPY_CYC     = 3,
  parameter int PUP_COPY_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic acc_rd_req,
  input  logic acc_wr_req,
  output logic acc_rd_grant,
  output logic acc_wr_grant,
  input  logic sw_store_go,
  input  logic sw_recall_go,
  input  logic sw_auto_cfg_go,
  input  logic sw_auto_cfg_val,
  input  logic busy_pin_in,
  output logic busy_drive_low,
  output logic busy_drive_high,
  output logic nv_erase,
  output logic nv_program,
  output logic sram_clear,
  output logic nv_to_sram,
  input  logic array_done,
  output logic write_latched,
  output logic auto_enable
);
  localparam int MAX_CYC = max2(max2(max2(GRACE_CYC, ERASE_CYC), max2(PROG_CYC, HIGH_CYC)),
                                max2(max2(CLEAR_CYC, COPY_CYC), PUP_COPY_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seq_state_e state, nxt;
  op_kind_e   kind, nxt_kind;
  logic       cnt_zero, step_done, cfg_apply;

  // named internal events
  logic store_done, recall_done, powerup_begin, timer_load;

  function automatic logic [CNT_W-1:0] state_len(seq_state_e s, op_kind_e k);
    int n;
    case (s)
      ST_GRACE: n = GRACE_CYC;
      ST_ERASE: n = ERASE_CYC;
      ST_PROG:  n = PROG_CYC;
      ST_HIGH:  n = HIGH_CYC;
      ST_CLEAR: n = CLEAR_CYC;
      ST_COPY:  n = (k == OP_POWERUP) ? PUP_COPY_CYC : COPY_CYC;
      default:  n = 1;
    endcase
    return CNT_W'(n - 1);
  endfunction

  assign step_done = cnt_zero && array_done;

  always_comb begin
    nxt       = state;
    nxt_kind  = kind;
    cfg_apply = 1'b0;
    case (state)
      ST_IDLE: begin
        if (!pwr_ok) begin
          if (auto_enable && store_qualifies(OP_AUTO, write_latched)) begin
            nxt = ST_GRACE; nxt_kind = OP_AUTO;
          end else begin
            nxt = ST_OFF;
          end
        end else if (!busy_pin_in) begin
          if (store_qualifies(OP_PIN, write_latched)) begin
            nxt = ST_GRACE; nxt_kind = OP_PIN;
          end else begin
            nxt = ST_HOLD;
          end
        end else if (sw_recall_go) begin
          nxt = ST_GRACE; nxt_kind = OP_SOFT_RECALL;
        end else if (sw_store_go) begin
          nxt = ST_GRACE; nxt_kind = OP_SOFT;
        end else begin
          cfg_apply = sw_auto_cfg_go;
        end
      end
      ST_GRACE: if (cnt_zero) nxt = (kind == OP_SOFT_RECALL) ? ST_CLEAR : ST_ERASE;
      ST_ERASE: if (step_done) nxt = ST_PROG;
      ST_PROG:  if (step_done) nxt = (kind == OP_AUTO) ? ST_OFF : ST_HIGH;
      ST_HIGH:  if (cnt_zero) nxt = ST_HOLD;
      ST_HOLD: begin
        if (!pwr_ok)          nxt = ST_OFF;
        else if (busy_pin_in) nxt = ST_IDLE;
      end
      ST_CLEAR: if (step_done) nxt = ST_COPY;
      ST_COPY:  if (step_done) nxt = ST_IDLE;
      ST_OFF: begin
        if (pwr_ok) begin
          nxt = ST_CLEAR; nxt_kind = OP_POWERUP;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kind  <= OP_SOFT;
    end else begin
      state <= nxt;
      kind  <= nxt_kind;
    end
  end

  assign timer_load    = (nxt != state);
  assign store_done    = (state == ST_PROG) && step_done;
  assign recall_done   = (state == ST_COPY) && step_done;
  assign powerup_begin = (state == ST_OFF) && pwr_ok;

  nvs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (state_len(nxt, nxt_kind)),
    .cnt_zero (cnt_zero)
  );

  nvs_access_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_ok      (pwr_ok),
    .rd_open     (((state == ST_IDLE) && busy_pin_in) || (state == ST_GRACE)),
    .wr_open     ((state == ST_IDLE) && busy_pin_in),
    .rd_req      (acc_rd_req),
    .wr_req      (acc_wr_req),
    .latch_clear (store_done || recall_done),
    .rd_grant    (acc_rd_grant),
    .wr_grant    (acc_wr_grant),
    .latched     (write_latched)
  );

  nvs_auto_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_go      (cfg_apply),
    .cfg_val     (sw_auto_cfg_val),
    .save        (store_done && saves_config(kind)),
    .reload      (powerup_begin),
    .auto_enable (auto_enable)
  );

  assign busy_drive_low  = drives_busy(state);
  assign busy_drive_high = (state == ST_HIGH);
  assign nv_erase        = (state == ST_ERASE);
  assign nv_program      = (state == ST_PROG);
  assign sram_clear      = (state == ST_CLEAR);
  assign nv_to_sram      = (state == ST_COPY);
endmodule

// File: rtl/nvs_seq_checker.sv
module nvs_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic acc_rd_grant,
  input logic acc_wr_grant,
  input logic busy_pin_in,
  input logic busy_drive_low,
  input logic busy_drive_high,
  input logic nv_erase,
  input logic nv_program,
  input logic sram_clear,
  input logic nv_to_sram,
  input logic write_latched
);
  logic any_step;
  assign any_step = nv_erase || nv_program || sram_clear || nv_to_sram;

  assert_write_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr_grant |=> write_latched);
  assert_program_end_clears_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_program) |-> !write_latched);
  assert_copy_end_clears_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_to_sram) |-> !write_latched);
  assert_low_line_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_pin_in |-> !acc_wr_grant);
  assert_erase_then_program_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_erase) |-> nv_program);
  assert_program_after_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_program) |-> $past(nv_erase));
  assert_drive_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_drive_low && busy_drive_high));
  assert_clear_then_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_clear) |-> nv_to_sram);
  assert_offline_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !(acc_rd_grant || acc_wr_grant));
  assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nv_erase, nv_program, sram_clear, nv_to_sram}));
  assert_step_blocks_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_step |-> !(acc_rd_grant || acc_wr_grant));
  assert_step_holds_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_step |-> busy_drive_low);
endmodule

bind nv_shadow_seq nvs_seq_checker u_seq_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .pwr_ok          (pwr_ok),
  .acc_rd_grant    (acc_rd_grant),
  .acc_wr_grant    (acc_wr_grant),
  .busy_pin_in     (busy_pin_in),
  .busy_drive_low  (busy_drive_low),
  .busy_drive_high (busy_drive_high),
  .nv_erase        (nv_erase),
  .nv_program      (nv_program),
  .sram_clear      (sram_clear),
  .nv_to_sram      (nv_to_sram),
  .write_latched   (write_latched)
);

// File: tb/nv_shadow_seq_bench.sv
module nv_shadow_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int G = 3, E = 4, P = 5, H = 2, C = 2, X = 3, U = 6;
  localparam int REQ_WIN = 4;
  localparam int WIN = 30;
  localparam int SRC_PIN = 0, SRC_SOFT = 1, SRC_AUTO_ON = 2, SRC_AUTO_OFF = 3, SRC_RECALL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic pwr_ok = 1'b1, acc_rd_req = 1'b0, acc_wr_req = 1'b0;
  logic sw_store_go = 1'b0, sw_recall_go = 1'b0, sw_auto_cfg_go = 1'b0, sw_auto_cfg_val = 1'b0;
  logic ext_low = 1'b0;
  logic acc_rd_grant, acc_wr_grant, busy_drive_low, busy_drive_high;
  logic nv_erase, nv_program, sram_clear, nv_to_sram, write_latched, auto_enable;
  logic array_done;
  logic busy_pin_in;
  assign busy_pin_in = !(busy_drive_low || ext_low);   // wired-AND with pull-up

  nv_shadow_seq #(
    .GRACE_CYC(G), .ERASE_CYC(E), .PROG_CYC(P), .HIGH_CYC(H),
    .CLEAR_CYC(C), .COPY_CYC(X), .PUP_COPY_CYC(U)
  ) u_nv_shadow_seq (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .acc_rd_req(acc_rd_req), .acc_wr_req(acc_wr_req),
    .acc_rd_grant(acc_rd_grant), .acc_wr_grant(acc_wr_grant),
    .sw_store_go(sw_store_go), .sw_recall_go(sw_recall_go),
    .sw_auto_cfg_go(sw_auto_cfg_go), .sw_auto_cfg_val(sw_auto_cfg_val),
    .busy_pin_in(busy_pin_in), .busy_drive_low(busy_drive_low),
    .busy_drive_high(busy_drive_high), .nv_erase(nv_erase),
    .nv_program(nv_program), .sram_clear(sram_clear), .nv_to_sram(nv_to_sram),
    .array_done(array_done), .write_latched(write_latched), .auto_enable(auto_enable)
  );

  // behavioural arrays
  logic [1:0] waddr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] sram_m [4];
  logic [7:0] nv_m   [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      array_done <= 1'b0;
      for (int i = 0; i < 4; i++) begin sram_m[i] <= 8'h00; nv_m[i] <= 8'h00; end
    end else begin
      array_done <= nv_erase || nv_program || sram_clear || nv_to_sram;
      if (acc_wr_grant) sram_m[waddr] <= wdata;
      for (int i = 0; i < 4; i++) begin
        if (nv_erase)   nv_m[i]   <= 8'h00;
        if (nv_program) nv_m[i]   <= sram_m[i];
        if (sram_clear) sram_m[i] <= 8'h00;
        if (nv_to_sram) sram_m[i] <= nv_m[i];
      end
    end
  end

  // cycle counters sampled at the falling edge
  logic mon_clr = 1'b0;
  int n_low, n_high, n_erase, n_prog, n_clear, n_copy, n_rd, n_wr;
  always @(negedge clk) begin
    if (mon_clr) begin
      n_low = 0; n_high = 0; n_erase = 0; n_prog = 0;
      n_clear = 0; n_copy = 0; n_rd = 0; n_wr = 0;
    end else begin
      n_low   += int'(busy_drive_low);
      n_high  += int'(busy_drive_high);
      n_erase += int'(nv_erase);
      n_prog  += int'(nv_program);
      n_clear += int'(sram_clear);
      n_copy  += int'(nv_to_sram);
      n_rd    += int'(acc_rd_grant);
      n_wr    += int'(acc_wr_grant);
    end
  end

  int errors = 0, checks = 0;
  bit exp_live = 1'b1, exp_saved = 1'b1;
  bit finished = 1'b0;

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic clear_counts();
    mon_clr = 1'b1; step(); mon_clr = 1'b0;
  endtask

  task automatic do_write(logic [1:0] a, logic [7:0] d);
    waddr = a; wdata = d; acc_wr_req = 1'b1; step(); acc_wr_req = 1'b0;
  endtask

  task automatic soft_store();
    sw_store_go = 1'b1; step(); sw_store_go = 1'b0;
    repeat (WIN) step();
    exp_saved = exp_live;
  endtask

  task automatic set_cfg(bit v);
    sw_auto_cfg_val = v; sw_auto_cfg_go = 1'b1; step(); sw_auto_cfg_go = 1'b0;
    exp_live = v;
  endtask

  function automatic bit store_runs(int src, bit lat);
    return (src == SRC_SOFT) || (((src == SRC_PIN) || (src == SRC_AUTO_ON)) && lat);
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic sweep_case(int src, bit lat);
    bit st, rc, manual;
    int hold;
    st = store_runs(src, lat);
    rc = (src == SRC_RECALL);
    manual = st && (src == SRC_PIN || src == SRC_SOFT);
    if (lat) do_write(2'd2, 8'h5A);
    else     soft_store();
    if (src == SRC_AUTO_ON || src == SRC_AUTO_OFF) begin
      set_cfg(src == SRC_AUTO_ON);
      check("R10", "auto_enable after cfg", int'(auto_enable), int'(exp_live));
    end
    clear_counts();
    // trigger in cycle 0
    hold = lat ? 2 : 6;
    case (src)
      SRC_PIN:    ext_low = 1'b1;
      SRC_SOFT:   sw_store_go = 1'b1;
      SRC_RECALL: sw_recall_go = 1'b1;
      default:    pwr_ok = 1'b0;
    endcase
    step();
    sw_store_go = 1'b0; sw_recall_go = 1'b0;
    acc_rd_req = 1'b1; acc_wr_req = 1'b1;
    for (int i = 1; i < WIN; i++) begin
      if (i == REQ_WIN + 1) begin acc_rd_req = 1'b0; acc_wr_req = 1'b0; end
      if (src == SRC_PIN && i == hold) ext_low = 1'b0;
      step();
    end
    if (src == SRC_PIN && !lat)
      check("R3", "line driven low on clean pin request", n_low, 0);
    else if (src == SRC_PIN)
      check("R4", "busy low cycles pin store", n_low, G + E + P);
    else if (src == SRC_SOFT)
      check("R6", "busy low cycles soft store", n_low, G + E + P);
    else if (rc)
      check("R7", "busy low cycles soft recall", n_low, G + C + X);
    else
      check("R8", "busy low cycles supply fail", n_low, st ? G + E + P : 0);
    check(st ? "R4" : "R3", "erase cycles", n_erase, st ? E : 0);
    check(st ? "R4" : "R3", "program cycles", n_prog, st ? P : 0);
    check("R7", "clear cycles", n_clear, rc ? C : 0);
    check("R7", "copy cycles", n_copy, rc ? X : 0);
    check("R5", "high pulse cycles", n_high, manual ? H : 0);
    check("R4", "reads granted in window", n_rd,
          (src == SRC_SOFT || rc || (src == SRC_PIN && lat)) ? min2(G, REQ_WIN) : 0);
    check("R11", "writes granted in window", n_wr, 0);
    if (manual) exp_saved = exp_live;
    if (src == SRC_AUTO_ON || src == SRC_AUTO_OFF) begin
      clear_counts();
      pwr_ok = 1'b1;
      repeat (WIN) step();
      check("R9", "power-up busy low cycles", n_low, C + U);
      check("R9", "power-up copy cycles", n_copy, U);
      check("R9", "auto_enable reloaded", int'(auto_enable), int'(exp_saved));
      exp_live = exp_saved;
      check("R2", "flag after power-up recall", int'(write_latched), 0);
    end else begin
      check("R2", "flag after window", int'(write_latched), (st || rc) ? 0 : int'(lat));
      check("R5", "line released", int'(busy_drive_low) + int'(busy_drive_high), 0);
    end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1", "drive low after reset", int'(busy_drive_low), 0);
    check("R1", "drive high after reset", int'(busy_drive_high), 0);
    check("R1", "auto_enable after reset", int'(auto_enable), 1);
    check("R1", "write flag after reset", int'(write_latched), 0);
    acc_rd_req = 1'b1; #1;
    check("R1", "read granted in idle", int'(acc_rd_grant), 1);
    acc_rd_req = 1'b0;
    step();
    // R2 write sets flag
    do_write(2'd0, 8'h11);
    check("R2", "write flag after write", int'(write_latched), 1);

    // sweep over trigger source and write-flag state
    for (int lat = 0; lat < 2; lat++)
      for (int src = 0; src < 5; src++)
        sweep_case(src, bit'(lat));

    // R7 data round trip
    do_write(2'd1, 8'hA5);
    soft_store();
    do_write(2'd1, 8'h3C);
    check("R7", "sram after overwrite", int'(sram_m[1]), 8'h3C);
    sw_recall_go = 1'b1; step(); sw_recall_go = 1'b0;
    repeat (WIN) step();
    check("R7", "sram after recall", int'(sram_m[1]), 8'hA5);
    check("R7", "shadow unchanged by recall", int'(nv_m[1]), 8'hA5);

    // R10 persistence: disable, save via soft store, then power cycle with dirty data
    set_cfg(1'b0);
    soft_store();
    do_write(2'd3, 8'h77);
    clear_counts();
    pwr_ok = 1'b0;
    repeat (WIN) step();
    check("R10", "no autostore when disabled", n_erase + n_prog, 0);
    pwr_ok = 1'b1;
    repeat (WIN) step();
    check("R10", "disabled setting survives power loss", int'(auto_enable), 0);
    check("R8", "dirty word lost without autostore", int'(sram_m[3]), 8'h00);
    set_cfg(1'b1);
    soft_store();
    check("R10", "re-enabled", int'(auto_enable), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule